// File: doc/BRIEF.md
# One-Wire Byte Transfer Engine with Strong Pullup

This block moves whole bytes on a one-wire bus by driving a lower bit-slot engine one slot at a time. A host picks an operation (write, read or touch), hands over a byte and pulses a start strobe. The engine issues eight slots, least significant bit first, gathers the level sampled in each slot into a result byte, and pulses done when the byte and any follow-up power interval are complete.

Parasitically powered devices need extra current right after certain writes. The host can stage a one-shot strong-pullup request, given as a number of milliseconds. The next write or touch takes it. When pullup hardware is enabled, the pullup drive is raised just as the final slot is requested and held until the interval has run out. When the hardware is disabled, the engine waits the same interval with the drive left low. Either way the request is then cleared. Milliseconds are counted from the same microsecond tick that paces the slot engine.

The controller has five states. IDLE goes to ISSUE on start. ISSUE always goes to WAIT_SLOT. WAIT_SLOT, when the slot completes, goes back to ISSUE for the next bit. After the last bit it goes to HOLD if a request is being taken, and to FINISH otherwise. HOLD goes to FINISH once the millisecond timer reaches zero. FINISH always goes back to IDLE.

Top module: `owb_byte_xfer`

## Requirements
- R1: With `cmd_op` = 2'b00 (write), the engine issues exactly eight slot requests, and slot i carries `cmd_data[i]` on `slot_wbit`, bit 0 first.
- R2: With `cmd_op` = 2'b01 (read), every slot carries a 1, and when `cmd_done` pulses `rd_data[i]` equals the `slot_rbit` returned for slot i.
- R3: With `cmd_op` = 2'b10 (touch), or the spare code 2'b11, which behaves as touch, slot i sends `cmd_data[i]` and `rd_data[i]` becomes the level sampled in that same slot.
- R4: When a nonzero request is pending, the hardware is enabled and the operation is a write or a touch, `spu_drive` rises in the same cycle as the request for the final slot (bit 7) and is low during the requests for bits 0 to 6.
- R5: After the final slot of such an operation, `spu_drive` stays high until N×`TICKS_PER_MS` `us_tick` pulses have been counted after the slot completes, N being the staged milliseconds. It is low again when `cmd_done` pulses.
- R6: With `spu_hw_en` low, a pending request causes the same N×`TICKS_PER_MS` tick wait before `cmd_done`, and `spu_drive` never rises.
- R7: A request is used by exactly one write or touch. The following write with no new load pulses `cmd_done` in the cycle after its final slot completes.
- R8: Loading a duration of zero with `spu_load` cancels a pending request.
- R9: A read neither uses nor clears a pending request. The request stays staged for the next write.
- R10: `spu_load` is ignored while a command is in progress.
- R11: `cmd_done` is a single-cycle pulse, and `slot_req` is never high for two cycles in a row.
- R12: After reset, `spu_drive`, `slot_req` and `cmd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond, shared with the slot engine |
| cmd_start | input | 1 | Starts a byte operation when idle |
| cmd_op | input | 2 | 00 write, 01 read, 10 touch, 11 touch |
| cmd_data | input | DATA_W | Byte to send |
| cmd_done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Sampled byte, valid when cmd_done pulses |
| spu_ms | input | MS_W | Pullup duration in milliseconds, zero cancels |
| spu_load | input | 1 | Stages spu_ms as the pending request |
| spu_hw_en | input | 1 | Pullup hardware present and enabled |
| spu_drive | output | 1 | Strong pullup drive |
| slot_req | output | 1 | One-cycle request for one bit slot |
| slot_wbit | output | 1 | Level to write in the requested slot |
| slot_done | input | 1 | Slot engine finished the slot |
| slot_rbit | input | 1 | Level sampled during the slot |

## Verification
The bench builds the engine with `TICKS_PER_MS` = 3 and `MS_W` = 8, so a pullup interval of one to three milliseconds lasts only a few dozen cycles. Every hold and wait can then be counted tick by tick against N×3. The microsecond tick comes every third cycle, so no tick can land in the two cycles between the timer reaching zero and the done pulse, and the expected tick counts are exact. The default of 1000 ticks per millisecond would only stretch the same windows.

// File: rtl/owb_pkg.sv
`timescale 1ns/1ps
package owb_pkg;

    typedef enum logic [1:0] {
        OWB_OP_WRITE = 2'b00,
        OWB_OP_READ  = 2'b01,
        OWB_OP_TOUCH = 2'b10,
        OWB_OP_SPARE = 2'b11
    } owb_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_SLOT,
        ST_HOLD,
        ST_FINISH
    } owb_state_e;

endpackage

// File: rtl/owb_ms_timer.sv
`timescale 1ns/1ps
module owb_ms_timer #(
    parameter int TICKS_PER_MS = 1000,
    parameter int MS_W         = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            us_tick,
    input  logic            load,
    input  logic [MS_W-1:0] load_ms,
    output logic            zero
);
    logic [MS_W-1:0] ms_left;
    logic            ms_step;

    generate
        if (TICKS_PER_MS == 1) begin : g_direct
            assign ms_step = us_tick;
        end else begin : g_div
            localparam int TCK_W = $clog2(TICKS_PER_MS);
            localparam logic [TCK_W-1:0] TCK_LAST = TCK_W'(TICKS_PER_MS - 1);
            logic [TCK_W-1:0] us_cnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    us_cnt <= '0;
                end else if (load) begin
                    us_cnt <= '0;
                end else if (us_tick && ms_left != '0) begin
                    if (us_cnt == TCK_LAST) begin
                        us_cnt <= '0;
                    end else begin
                        us_cnt <= us_cnt + 1'b1;
                    end
                end
            end

            assign ms_step = us_tick && (us_cnt == TCK_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms_left <= '0;
        end else if (load) begin
            ms_left <= load_ms;
        end else if (ms_step && ms_left != '0) begin
            ms_left <= ms_left - 1'b1;
        end
    end

    assign zero = (ms_left == '0);
endmodule

// File: rtl/owb_spu_req.sv
`timescale 1ns/1ps
module owb_spu_req #(
    parameter int MS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [MS_W-1:0] load_ms,
    input  logic            consume,
    output logic [MS_W-1:0] pend_ms,
    output logic            pending
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ms <= '0;
        end else if (load_en) begin
            pend_ms <= load_ms;
        end else if (consume) begin
            pend_ms <= '0;
        end
    end

    assign pending = (pend_ms != '0);
endmodule

// File: rtl/owb_bit_shifter.sv
`timescale 1ns/1ps
module owb_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              shift_in,
    output logic              lsb,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {shift_in, q[DATA_W-1:1]};
        end
    end

    assign lsb = q[0];
endmodule

// File: rtl/owb_byte_fsm.sv
`timescale 1ns/1ps
module owb_byte_fsm
    import owb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic [1:0] cmd_op,
    input  logic       hw_en,
    input  logic       slot_done,
    input  logic       pending,
    input  logic       tmr_zero,
    output logic       busy,
    output logic       sh_load,
    output logic       sh_shift,
    output logic       send_ones,
    output logic       slot_req,
    output logic       tmr_load,
    output logic       drive,
    output logic       done
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    owb_state_e       state, state_nx;
    owb_op_e          op_q;
    logic             hw_q;
    logic [IDX_W-1:0] idx;
    logic             at_last;
    logic             takes;

    assign at_last = (idx == IDX_LAST);
    assign takes   = pending && (op_q != OWB_OP_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OWB_OP_WRITE;
            hw_q <= 1'b0;
            idx  <= '0;
        end else if (state == ST_IDLE && cmd_start) begin
            op_q <= owb_op_e'(cmd_op);
            hw_q <= hw_en;
            idx  <= '0;
        end else if (state == ST_WAIT_SLOT && slot_done && !at_last) begin
            idx <= idx + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (cmd_start) state_nx = ST_ISSUE;
            ST_ISSUE:     state_nx = ST_WAIT_SLOT;
            ST_WAIT_SLOT: begin
                if (slot_done) begin
                    if (!at_last)   state_nx = ST_ISSUE;
                    else if (takes) state_nx = ST_HOLD;
                    else            state_nx = ST_FINISH;
                end
            end
            ST_HOLD:      if (tmr_zero) state_nx = ST_FINISH;
            ST_FINISH:    state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = (state != ST_IDLE);
        sh_load   = (state == ST_IDLE) && cmd_start;
        sh_shift  = (state == ST_WAIT_SLOT) && slot_done;
        send_ones = (op_q == OWB_OP_READ);
        slot_req  = (state == ST_ISSUE);
        tmr_load  = (state == ST_WAIT_SLOT) && slot_done && at_last && takes;
        done      = (state == ST_FINISH);
        drive     = 1'b0;
        unique case (state)
            ST_ISSUE, ST_WAIT_SLOT: drive = hw_q && at_last && takes;
            ST_HOLD:                drive = hw_q;
            default:                drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/owb_byte_xfer.sv
`timescale 1ns/1ps
module owb_byte_xfer #(
    parameter int DATA_W       = 8,
    parameter int MS_W         = 16,
    parameter int TICKS_PER_MS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_done,
    output logic [DATA_W-1:0] rd_data,
    input  logic [MS_W-1:0]   spu_ms,
    input  logic              spu_load,
    input  logic              spu_hw_en,
    output logic              spu_drive,
    output logic              slot_req,
    output logic              slot_wbit,
    input  logic              slot_done,
    input  logic              slot_rbit
);
    logic            busy, sh_load, sh_shift, send_ones, sh_lsb;
    logic            tmr_load, tmr_zero, pending;
    logic [MS_W-1:0] pend_ms;

    owb_byte_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_op    (cmd_op),
        .hw_en     (spu_hw_en),
        .slot_done (slot_done),
        .pending   (pending),
        .tmr_zero  (tmr_zero),
        .busy      (busy),
        .sh_load   (sh_load),
        .sh_shift  (sh_shift),
        .send_ones (send_ones),
        .slot_req  (slot_req),
        .tmr_load  (tmr_load),
        .drive     (spu_drive),
        .done      (cmd_done)
    );

    owb_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (cmd_data),
        .shift    (sh_shift),
        .shift_in (slot_rbit),
        .lsb      (sh_lsb),
        .q        (rd_data)
    );

    owb_spu_req #(.MS_W(MS_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (spu_load && !busy),
        .load_ms (spu_ms),
        .consume (tmr_load),
        .pend_ms (pend_ms),
        .pending (pending)
    );

    owb_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .load    (tmr_load),
        .load_ms (pend_ms),
        .zero    (tmr_zero)
    );

    assign slot_wbit = send_ones ? 1'b1 : sh_lsb;
endmodule

// File: rtl/owb_byte_chk.sv
`timescale 1ns/1ps
module owb_byte_chk (
    input logic clk,
    input logic rst_n,
    input logic slot_req,
    input logic spu_drive,
    input logic spu_hw_en,
    input logic cmd_done,
    input logic tmr_zero
);
    a_r4_drive_rises_with_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spu_drive) |-> slot_req);

    a_r5_release_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spu_drive) |-> $past(tmr_zero));

    a_r5_low_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !spu_drive);

    a_r6_drive_needs_hw: assert property (@(posedge clk) disable iff (!rst_n)
        spu_drive |-> spu_hw_en);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    a_r11_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |=> !slot_req);
endmodule

bind owb_byte_xfer owb_byte_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_req  (slot_req),
    .spu_drive (spu_drive),
    .spu_hw_en (spu_hw_en),
    .cmd_done  (cmd_done),
    .tmr_zero  (tmr_zero)
);

// File: tb/owb_byte_xfer_tb_top.sv
`timescale 1ns/1ps
module owb_byte_xfer_tb_top;
    localparam int DW = 8;
    localparam int MSW = 8;
    localparam int TPM = 3;
    localparam int TICK_DIV = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, us_tick, cmd_start, cmd_done, spu_load, spu_hw_en, spu_drive;
    logic slot_req, slot_wbit, slot_done, slot_rbit;
    logic [1:0] cmd_op;
    logic [DW-1:0] cmd_data, rd_data;
    logic [MSW-1:0] spu_ms;

    owb_byte_xfer #(.DATA_W(DW), .MS_W(MSW), .TICKS_PER_MS(TPM)) dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_start(cmd_start),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_done(cmd_done), .rd_data(rd_data),
        .spu_ms(spu_ms), .spu_load(spu_load), .spu_hw_en(spu_hw_en), .spu_drive(spu_drive),
        .slot_req(slot_req), .slot_wbit(slot_wbit), .slot_done(slot_done), .slot_rbit(slot_rbit)
    );

    typedef struct {
        logic [7:0] wexp;
        logic [7:0] rexp;
        int         ticks;
        bit         drv;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    logic [7:0] mdl_resp = 8'hFF;
    int mdl_idx = 0;

    task automatic check_eq(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // microsecond tick
    initial begin
        us_tick = 1'b0;
        forever begin
            for (int k = 0; k < TICK_DIV; k++) begin
                @(posedge clk); #2;
                us_tick = (k == 0);
            end
        end
    end

    // slot engine model: open-drain AND of written level and device response
    initial begin
        logic wb;
        slot_done = 1'b0;
        slot_rbit = 1'b0;
        forever begin
            @(posedge clk); #2;
            slot_done = 1'b0;
            if (slot_req) begin
                wb = slot_wbit;
                @(posedge clk); #2;
                slot_rbit = wb & mdl_resp[mdl_idx[2:0]];
                mdl_idx++;
                slot_done = 1'b1;
            end
        end
    end

    // monitor / scoreboard
    int cyc = 0, last_done_cyc = 0, tick_cnt = 0, bitn = 0;
    logic [7:0] wbits = '0;
    logic [7:0] drv_req = '0;
    bit drv_any = 0, prev_done = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (prev_done) check_eq("R11", "done pulse width", int'(cmd_done), 0);
                prev_done = cmd_done;
                if (slot_req && bitn < 8) begin
                    wbits[bitn] = slot_wbit;
                    drv_req[bitn] = spu_drive;
                    bitn++;
                end
                if (spu_drive) drv_any = 1;
                if (slot_done) begin
                    last_done_cyc = cyc;
                    tick_cnt = 0;
                end else if (us_tick) begin
                    tick_cnt++;
                end
                if (cmd_done) begin
                    if (sbq.size() == 0) begin
                        check_eq("R11", "unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        check_eq(e.tag, "slot count", bitn, 8);
                        check_eq(e.tag, "written bits", int'(wbits), int'(e.wexp));
                        check_eq(e.tag, "rd_data", int'(rd_data), int'(e.rexp));
                        if (e.ticks > 0) check_eq(e.tag, "ticks before done", tick_cnt, e.ticks);
                        else check_eq(e.tag, "done gap after last slot", cyc - last_done_cyc, 1);
                        check_eq(e.tag, "drive seen", int'(drv_any), int'(e.drv));
                        check_eq(e.tag, "drive at bit7 request", int'(drv_req[7]), int'(e.drv));
                        check_eq(e.tag, "drive at bits0-6 requests", int'(drv_req[6:0]), 0);
                        check_eq(e.tag, "drive low at done", int'(spu_drive), 0);
                    end
                    bitn = 0;
                    drv_any = 0;
                    wbits = '0;
                    drv_req = '0;
                    done_cnt++;
                end
            end
        end
    end

    task automatic load_ms(logic [MSW-1:0] ms);
        @(posedge clk); #2;
        spu_ms = ms;
        spu_load = 1'b1;
        @(posedge clk); #2;
        spu_load = 1'b0;
    endtask

    task automatic run_cmd(logic [1:0] op, logic [7:0] data, logic [7:0] resp,
                           int ticks, bit drv, string tag, bit mid_load);
        exp_t e;
        int d0;
        e.wexp  = (op == 2'b01) ? 8'hFF : data;
        e.rexp  = (op == 2'b01) ? resp : (data & resp);
        e.ticks = ticks;
        e.drv   = drv;
        e.tag   = tag;
        sbq.push_back(e);
        d0 = done_cnt;
        @(posedge clk); #2;
        mdl_resp = resp;
        mdl_idx = 0;
        cmd_op = op;
        cmd_data = data;
        cmd_start = 1'b1;
        @(posedge clk); #2;
        cmd_start = 1'b0;
        if (mid_load) begin
            repeat (3) @(posedge clk);
            #2;
            spu_ms = 8'd5;
            spu_load = 1'b1;
            @(posedge clk); #2;
            spu_load = 1'b0;
        end
        while (done_cnt == d0) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cmd_start = 1'b0;
        cmd_op = 2'b00;
        cmd_data = '0;
        spu_ms = '0;
        spu_load = 1'b0;
        spu_hw_en = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R12", "reset spu_drive", int'(spu_drive), 0);
        check_eq("R12", "reset slot_req", int'(slot_req), 0);
        check_eq("R12", "reset cmd_done", int'(cmd_done), 0);

        run_cmd(2'b00, 8'hA5, 8'hFF, 0, 0, "R1", 0);
        run_cmd(2'b01, 8'h00, 8'h3C, 0, 0, "R2", 0);
        run_cmd(2'b10, 8'hF0, 8'h5A, 0, 0, "R3", 0);
        run_cmd(2'b11, 8'h0F, 8'hFF, 0, 0, "R3", 0);

        load_ms(8'd2);
        run_cmd(2'b00, 8'h81, 8'hFF, 2 * TPM, 1, "R5", 0);
        run_cmd(2'b00, 8'h7E, 8'hFF, 0, 0, "R7", 0);

        load_ms(8'd3);
        run_cmd(2'b01, 8'h00, 8'hC3, 0, 0, "R9", 0);
        run_cmd(2'b00, 8'h55, 8'hFF, 3 * TPM, 1, "R9", 0);

        load_ms(8'd4);
        load_ms(8'd0);
        run_cmd(2'b00, 8'h3A, 8'hFF, 0, 0, "R8", 0);

        spu_hw_en = 1'b0;
        load_ms(8'd2);
        run_cmd(2'b00, 8'hC4, 8'hFF, 2 * TPM, 0, "R6", 0);
        spu_hw_en = 1'b1;

        run_cmd(2'b00, 8'h12, 8'hFF, 0, 0, "R10", 1);
        run_cmd(2'b00, 8'h34, 8'hFF, 0, 0, "R10", 0);

        load_ms(8'd1);
        run_cmd(2'b10, 8'hE7, 8'h99, 1 * TPM, 1, "R4", 0);

        check_eq("R11", "scoreboard drained", sbq.size(), 0);
        summary();
        $finish;
    end
endmodule